// File: doc/BRIEF.md
# Memory-ordering unit with split store buffers

This unit sits between a core's commit stage and its data cache and keeps the core sequentially consistent at low cost. Every committed store and every load ready to commit carries an access class: private, shared read-only, or shared read-write. An instruction hint bit marks the access as private. Without the hint, a two-bit attribute from address translation gives the class. Private stores are collected in a small unordered buffer that merges stores to the same address. All other stores queue in an in-order shared FIFO.

Loads to private or read-only data may commit at once. A shared read-write load is held only while the shared FIFO has entries. It never waits on the private buffer. Loads first look in both buffers for a matching address: the youngest shared entry wins, then the private entry, and otherwise the cache read port supplies the data. Both buffers drain through one cache write port with a valid/ready handshake. The shared FIFO has priority on that port, so held loads are released as early as possible.

Top module: `mem_order_unit`

## Requirements
- R1: The class is private when the hint bit is 1, whatever the attribute. With hint 0, attribute 2'b01 means private, 2'b10 means shared read-only, and 2'b00 or 2'b11 means shared read-write.
- R2: An accepted private store goes to the private buffer. It does not hold back a later shared read-write load.
- R3: The shared FIFO presents its entries on the write port strictly in the order it accepted them.
- R4: `ld_ready_o` is 1 for a private or shared read-only load, whatever either buffer holds.
- R5: `ld_ready_o` is 0 for a shared read-write load while the shared FIFO is not empty, and 1 once it is empty.
- R6: A private store to an address the private buffer already holds overwrites that entry's data and takes no new slot. Every private entry leaves the buffer once, with its latest data.
- R7: `ld_data_o` is the youngest matching shared FIFO entry; failing that, the matching private entry; failing that, `cache_rd_data_i`. A store is visible to loads from the cycle after it is accepted.
- R8: `st_ready_o` is 0 when the store's target buffer is full. A private store whose address hits an existing entry stays ready even when the private buffer is full.
- R9: When both buffers hold entries, the write port carries the shared FIFO head.
- R10: After reset both buffers are empty: `cwr_valid_o` is 0 and a shared read-write load is ready.
- R11: An entry leaves its buffer only in a cycle with `cwr_valid_o` and `cwr_ready_i` both high. While `cwr_ready_i` is low, the entry stays in its buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Committed store present |
| st_ready_o | output | 1 | Store can be accepted this cycle |
| st_addr_i | input | AW | Store address |
| st_data_i | input | DW | Store data |
| st_hint_i | input | 1 | Private hint bit for the store |
| st_attr_i | input | 2 | Translation attribute for the store |
| ld_valid_i | input | 1 | Load waiting to commit |
| ld_ready_o | output | 1 | Load may commit this cycle |
| ld_addr_i | input | AW | Load address |
| ld_hint_i | input | 1 | Private hint bit for the load |
| ld_attr_i | input | 2 | Translation attribute for the load |
| ld_data_o | output | DW | Load data, forwarded or from the cache |
| cache_rd_addr_o | output | AW | Cache read address |
| cache_rd_data_i | input | DW | Cache read data, same cycle |
| cwr_valid_o | output | 1 | Cache write request |
| cwr_ready_i | input | 1 | Cache accepts the write |
| cwr_addr_o | output | AW | Cache write address |
| cwr_data_o | output | DW | Cache write data |

## Verification
Every output is combinational on registered buffer state and the present inputs. So `st_ready_o`, `ld_ready_o`, `ld_data_o` and the write-port signals are due in the same cycle as the stimulus. Their effect on the buffers shows one clock edge later. The bench drives inputs on the falling edge and samples one nanosecond later. It applies accepted stores and write-port handshakes to its own queue and map model only after the following rising edge. Each expectation therefore comes from the buffer contents as of the previous edge.

// File: rtl/mou_pkg.sv
package mou_pkg;
  typedef enum logic [1:0] {
    ACC_SHRW = 2'd0,
    ACC_PRIV = 2'd1,
    ACC_SHRO = 2'd2
  } acc_class_e;

  localparam logic [1:0] PAGE_PRIV = 2'b01;
  localparam logic [1:0] PAGE_RO   = 2'b10;

  // hint overrides the translation attribute
  function automatic acc_class_e classify(input logic hint, input logic [1:0] attr);
    if (hint)                   return ACC_PRIV;
    else if (attr == PAGE_PRIV) return ACC_PRIV;
    else if (attr == PAGE_RO)   return ACC_SHRO;
    else                        return ACC_SHRW;
  endfunction
endpackage

// File: rtl/mou_shared_fifo.sv
module mou_shared_fifo #(
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic          full_o,
  output logic          empty_o,
  output logic [AW-1:0] head_addr_o,
  output logic [DW-1:0] head_data_o,
  input  logic [AW-1:0] lkp_addr_i,
  output logic          lkp_hit_o,
  output logic [DW-1:0] lkp_data_o
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o      = (cnt_q == CW'(DEPTH));
  assign empty_o     = (cnt_q == '0);
  assign head_addr_o = addr_q[rd_ptr_q];
  assign head_data_o = data_q[rd_ptr_q];

  // oldest to youngest; the last match is the youngest
  always_comb begin
    logic [PW:0] pos;
    lkp_hit_o  = 1'b0;
    lkp_data_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      pos = {1'b0, rd_ptr_q} + (PW+1)'(i);
      if (pos >= (PW+1)'(DEPTH)) pos = pos - (PW+1)'(DEPTH);
      if (CW'(i) < cnt_q && addr_q[pos[PW-1:0]] == lkp_addr_i) begin
        lkp_hit_o  = 1'b1;
        lkp_data_o = data_q[pos[PW-1:0]];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        addr_q[i] <= '0;
        data_q[i] <= '0;
      end
    end else begin
      if (push_i) begin
        addr_q[wr_ptr_q] <= push_addr_i;
        data_q[wr_ptr_q] <= push_data_i;
        wr_ptr_q         <= bump(wr_ptr_q);
      end
      if (pop_i) rd_ptr_q <= bump(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_underflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/mou_private_buf.sv
module mou_private_buf #(
  parameter int unsigned AW      = 8,
  parameter int unsigned DW      = 32,
  parameter int unsigned ENTRIES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          wr_hit_o,
  output logic          full_o,
  output logic          drain_valid_o,
  output logic [AW-1:0] drain_addr_o,
  output logic [DW-1:0] drain_data_o,
  input  logic          drain_i,
  input  logic [AW-1:0] lkp_addr_i,
  output logic          lkp_hit_o,
  output logic [DW-1:0] lkp_data_o
);
  localparam int unsigned IW = $clog2(ENTRIES);

  logic [ENTRIES-1:0] valid_q;
  logic [AW-1:0]      addr_q [ENTRIES];
  logic [DW-1:0]      data_q [ENTRIES];
  logic [IW-1:0]      hit_idx, free_idx, drain_idx, tgt_idx;
  logic               dup;

  assign full_o        = &valid_q;
  assign drain_valid_o = |valid_q;
  assign drain_addr_o  = addr_q[drain_idx];
  assign drain_data_o  = data_q[drain_idx];
  assign tgt_idx       = wr_hit_o ? hit_idx : free_idx;

  // downward scans: the lowest index wins
  always_comb begin
    wr_hit_o   = 1'b0;
    hit_idx    = '0;
    free_idx   = '0;
    drain_idx  = '0;
    lkp_hit_o  = 1'b0;
    lkp_data_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (valid_q[i] && addr_q[i] == wr_addr_i) begin
        wr_hit_o = 1'b1;
        hit_idx  = IW'(i);
      end
      if (!valid_q[i]) free_idx = IW'(i);
      if (valid_q[i])  drain_idx = IW'(i);
      if (valid_q[i] && addr_q[i] == lkp_addr_i) begin
        lkp_hit_o  = 1'b1;
        lkp_data_o = data_q[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        addr_q[i] <= '0;
        data_q[i] <= '0;
      end
    end else begin
      if (drain_i) valid_q[drain_idx] <= 1'b0;
      // a merge into the draining entry keeps it alive with the new data
      if (wr_i) begin
        valid_q[tgt_idx] <= 1'b1;
        addr_q[tgt_idx]  <= wr_addr_i;
        data_q[tgt_idx]  <= wr_data_i;
      end
    end
  end

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      for (int j = i + 1; j < ENTRIES; j++)
        if (valid_q[i] && valid_q[j] && addr_q[i] == addr_q[j]) dup = 1'b1;
  end

  assert_unique_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dup);
  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wr_hit_o) |-> !full_o);
  assert_drain_valid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_i |-> drain_valid_o);
endmodule

// File: rtl/mem_order_unit.sv
module mem_order_unit
  import mou_pkg::*;
#(
  parameter int unsigned AW         = 8,
  parameter int unsigned DW         = 32,
  parameter int unsigned SQ_DEPTH   = 4,
  parameter int unsigned PB_ENTRIES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          st_valid_i,
  output logic          st_ready_o,
  input  logic [AW-1:0] st_addr_i,
  input  logic [DW-1:0] st_data_i,
  input  logic          st_hint_i,
  input  logic [1:0]    st_attr_i,
  input  logic          ld_valid_i,
  output logic          ld_ready_o,
  input  logic [AW-1:0] ld_addr_i,
  input  logic          ld_hint_i,
  input  logic [1:0]    ld_attr_i,
  output logic [DW-1:0] ld_data_o,
  output logic [AW-1:0] cache_rd_addr_o,
  input  logic [DW-1:0] cache_rd_data_i,
  output logic          cwr_valid_o,
  input  logic          cwr_ready_i,
  output logic [AW-1:0] cwr_addr_o,
  output logic [DW-1:0] cwr_data_o
);
  acc_class_e    st_class, ld_class;
  logic          st_priv, st_fire;
  logic          sq_full, sq_empty, sq_pop, sq_hit;
  logic [AW-1:0] sq_head_addr;
  logic [DW-1:0] sq_head_data, sq_fwd;
  logic          pb_full, pb_wr_hit, pb_dvalid, pb_drain, pb_hit;
  logic [AW-1:0] pb_daddr;
  logic [DW-1:0] pb_ddata, pb_fwd;
  logic          sel_shared;

  assign st_class = classify(st_hint_i, st_attr_i);
  assign ld_class = classify(ld_hint_i, ld_attr_i);
  assign st_priv  = (st_class == ACC_PRIV);

  assign st_ready_o = st_priv ? (!pb_full || pb_wr_hit) : !sq_full;
  assign st_fire    = st_valid_i && st_ready_o;

  assign ld_ready_o      = (ld_class != ACC_SHRW) || sq_empty;
  assign cache_rd_addr_o = ld_valid_i ? ld_addr_i : '0;
  assign ld_data_o       = sq_hit ? sq_fwd : (pb_hit ? pb_fwd : cache_rd_data_i);

  // shared FIFO owns the write port whenever it is not empty
  assign sel_shared  = !sq_empty;
  assign cwr_valid_o = sel_shared || pb_dvalid;
  assign cwr_addr_o  = sel_shared ? sq_head_addr : pb_daddr;
  assign cwr_data_o  = sel_shared ? sq_head_data : pb_ddata;
  assign sq_pop      = sel_shared && cwr_ready_i;
  assign pb_drain    = !sel_shared && pb_dvalid && cwr_ready_i;

  mou_shared_fifo #(.AW(AW), .DW(DW), .DEPTH(SQ_DEPTH)) u_sq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (st_fire && !st_priv),
    .push_addr_i (st_addr_i),
    .push_data_i (st_data_i),
    .pop_i       (sq_pop),
    .full_o      (sq_full),
    .empty_o     (sq_empty),
    .head_addr_o (sq_head_addr),
    .head_data_o (sq_head_data),
    .lkp_addr_i  (ld_addr_i),
    .lkp_hit_o   (sq_hit),
    .lkp_data_o  (sq_fwd)
  );

  mou_private_buf #(.AW(AW), .DW(DW), .ENTRIES(PB_ENTRIES)) u_pb (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (st_fire && st_priv),
    .wr_addr_i     (st_addr_i),
    .wr_data_i     (st_data_i),
    .wr_hit_o      (pb_wr_hit),
    .full_o        (pb_full),
    .drain_valid_o (pb_dvalid),
    .drain_addr_o  (pb_daddr),
    .drain_data_o  (pb_ddata),
    .drain_i       (pb_drain),
    .lkp_addr_i    (ld_addr_i),
    .lkp_hit_o     (pb_hit),
    .lkp_data_o    (pb_fwd)
  );

  assert_rw_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && ld_ready_o && ld_class == ACC_SHRW) |-> !sq_pop);
  assert_fast_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && ld_class != ACC_SHRW) |-> ld_ready_o);
  assert_port_prio_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pb_drain |-> sq_empty);
  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cwr_valid_o && !cwr_ready_i) |=> cwr_valid_o);
endmodule

// File: tb/mem_order_unit_tb_top.sv
module mem_order_unit_tb_top;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 32;
  localparam int unsigned SQD = 4;
  localparam int unsigned PBN = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          st_valid = 1'b0, st_hint = 1'b0, ld_valid = 1'b0, ld_hint = 1'b0;
  logic          cwr_ready = 1'b0;
  logic [1:0]    st_attr = '0, ld_attr = '0;
  logic [AW-1:0] st_addr = '0, ld_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic          st_ready, ld_ready, cwr_valid;
  logic [DW-1:0] ld_data, cache_rd_data, cwr_data;
  logic [AW-1:0] cache_rd_addr, cwr_addr;

  int errors = 0;
  int checks = 0;

  logic [AW-1:0] sq_a [$];
  logic [DW-1:0] sq_d [$];
  logic [DW-1:0] pm [logic [AW-1:0]];

  always #5 clk = ~clk;

  assign cache_rd_data = {{(DW-AW){1'b0}}, cache_rd_addr} ^ 32'hC0DE_0000;

  mem_order_unit #(.AW(AW), .DW(DW), .SQ_DEPTH(SQD), .PB_ENTRIES(PBN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(st_valid), .st_ready_o(st_ready), .st_addr_i(st_addr),
    .st_data_i(st_data), .st_hint_i(st_hint), .st_attr_i(st_attr),
    .ld_valid_i(ld_valid), .ld_ready_o(ld_ready), .ld_addr_i(ld_addr),
    .ld_hint_i(ld_hint), .ld_attr_i(ld_attr), .ld_data_o(ld_data),
    .cache_rd_addr_o(cache_rd_addr), .cache_rd_data_i(cache_rd_data),
    .cwr_valid_o(cwr_valid), .cwr_ready_i(cwr_ready),
    .cwr_addr_o(cwr_addr), .cwr_data_o(cwr_data)
  );

  // R1: 1 private, 2 read-only, 0 read-write
  function automatic int cls(input logic h, input logic [1:0] at);
    if (h) return 1;
    if (at == 2'b01) return 1;
    if (at == 2'b10) return 2;
    return 0;
  endfunction

  function automatic logic [DW-1:0] exp_load(input logic [AW-1:0] a);
    for (int i = sq_a.size() - 1; i >= 0; i--)
      if (sq_a[i] == a) return sq_d[i];
    if (pm.exists(a)) return pm[a];
    return {{(DW-AW){1'b0}}, a} ^ 32'hC0DE_0000;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic sv, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                      input logic sh, input logic [1:0] sat,
                      input logic lv, input logic [AW-1:0] la, input logic lh,
                      input logic [1:0] lat, input logic wr, input string ld_tag);
    logic e_st, e_ld, e_cv, fire;
    logic [DW-1:0] e_ldd;
    logic [AW-1:0] fa;
    @(negedge clk);
    st_valid = sv; st_addr = sa; st_data = sd; st_hint = sh; st_attr = sat;
    ld_valid = lv; ld_addr = la; ld_hint = lh; ld_attr = lat; cwr_ready = wr;
    #1;
    e_st = (cls(sh, sat) == 1) ? ((pm.num() < PBN) || pm.exists(sa)) : (sq_a.size() < SQD);
    e_ld = (cls(lh, lat) != 0) || (sq_a.size() == 0);
    e_cv = (sq_a.size() > 0) || (pm.num() > 0);
    if (sv) check(st_ready == e_st, "R8", "st_ready", DW'(st_ready), DW'(e_st));
    check(ld_ready == e_ld, (ld_tag != "") ? ld_tag : ((cls(lh, lat) == 0) ? "R5" : "R4"),
          "ld_ready", DW'(ld_ready), DW'(e_ld));
    if (lv) begin
      e_ldd = exp_load(la);
      check(ld_data == e_ldd, "R7", "ld_data", ld_data, e_ldd);
    end
    check(cwr_valid == e_cv, e_cv ? "R11" : "R10", "cwr_valid", DW'(cwr_valid), DW'(e_cv));
    fire = cwr_valid && wr;
    fa = cwr_addr;
    if (cwr_valid && sq_a.size() > 0) begin
      check(cwr_addr == sq_a[0], (pm.num() > 0) ? "R9" : "R3", "cwr_addr",
            DW'(cwr_addr), DW'(sq_a[0]));
      check(cwr_data == sq_d[0], "R3", "cwr_data", cwr_data, sq_d[0]);
    end else if (cwr_valid) begin
      check(pm.exists(cwr_addr), "R6", "private addr held", DW'(cwr_addr), DW'(cwr_addr));
      if (pm.exists(cwr_addr))
        check(cwr_data == pm[cwr_addr], "R6", "private data", cwr_data, pm[cwr_addr]);
    end
    @(posedge clk);
    if (fire) begin
      if (sq_a.size() > 0) begin
        void'(sq_a.pop_front());
        void'(sq_d.pop_front());
      end else if (pm.exists(fa)) pm.delete(fa);
    end
    if (sv && e_st) begin
      if (cls(sh, sat) == 1) pm[sa] = sd;
      else begin
        sq_a.push_back(sa);
        sq_d.push_back(sd);
      end
    end
  endtask

  task automatic idle(input logic wr);
    step(1'b0, '0, '0, 1'b0, 2'b00, 1'b0, '0, 1'b0, 2'b00, wr, "");
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: empty after reset, read-write load not held
    step(1'b0, '0, '0, 1'b0, 2'b00, 1'b1, 8'h05, 1'b0, 2'b00, 1'b0, "R10");

    // R2: private store only, then read-write load stays ready
    step(1'b1, 8'h50, 32'h1111_0001, 1'b1, 2'b00, 1'b0, '0, 1'b0, 2'b00, 1'b0, "");
    step(1'b0, '0, '0, 1'b0, 2'b00, 1'b1, 8'h50, 1'b0, 2'b00, 1'b0, "R2");
    while (cwr_valid) idle(1'b1);

    // private buffer full; R8 on distinct address, R6 merge on a held one
    for (int i = 0; i < PBN; i++)
      step(1'b1, AW'(8'h20 + i), 32'hA000_0000 + i, 1'b1, 2'b10, 1'b0, '0, 1'b0, 2'b00, 1'b0, "");
    step(1'b1, 8'h24, 32'hDEAD_0024, 1'b1, 2'b00, 1'b0, '0, 1'b0, 2'b00, 1'b0, "");
    step(1'b1, 8'h21, 32'hBEEF_0021, 1'b0, 2'b01, 1'b1, 8'h21, 1'b1, 2'b00, 1'b0, "");
    step(1'b0, '0, '0, 1'b0, 2'b00, 1'b1, 8'h21, 1'b0, 2'b01, 1'b0, "R1");

    // shared FIFO full with a repeated address: R8, R5, R4, R1, R7
    step(1'b1, 8'h30, 32'h3000_0001, 1'b0, 2'b00, 1'b0, '0, 1'b0, 2'b00, 1'b0, "");
    step(1'b1, 8'h31, 32'h3000_0002, 1'b0, 2'b11, 1'b0, '0, 1'b0, 2'b00, 1'b0, "");
    step(1'b1, 8'h30, 32'h3000_0003, 1'b0, 2'b10, 1'b0, '0, 1'b0, 2'b00, 1'b0, "");
    step(1'b1, 8'h32, 32'h3000_0004, 1'b0, 2'b00, 1'b1, 8'h30, 1'b0, 2'b00, 1'b0, "R5");
    step(1'b1, 8'h33, 32'h3000_0005, 1'b0, 2'b00, 1'b1, 8'h31, 1'b0, 2'b10, 1'b0, "R4");
    step(1'b0, '0, '0, 1'b0, 2'b00, 1'b1, 8'h30, 1'b0, 2'b11, 1'b0, "R1");
    step(1'b0, '0, '0, 1'b0, 2'b00, 1'b1, 8'h22, 1'b1, 2'b00, 1'b0, "R1");
    // R11 hold, then R9/R3 drain order
    idle(1'b0);
    while (cwr_valid) idle(1'b1);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] a1, a2;
      a1 = AW'($urandom % 12);
      a2 = AW'($urandom % 12);
      step(($urandom % 10) < 6, a1, $urandom, ($urandom % 8) == 0, 2'($urandom),
           ($urandom % 10) < 6, a2, ($urandom % 8) == 0, 2'($urandom),
           ($urandom % 10) < ((n / 500) % 2 == 0 ? 3 : 7), "");
    end
    while (cwr_valid) idle(1'b1);
    idle(1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule